// File: doc/BRIEF.md
# Audio Serial-Port Clock Master and Serializer

This block drives a multi-line audio serial port as the clock master. It runs on the master clock and produces the bit clock by an integer division of that clock. The divide ratio is the master clock frequency divided by the product of the sample rate and the bits per frame. The software that picks the rate works that ratio out and hands it in. The block also produces the word clock, or in TDM the frame sync. It shifts a parallel frame of channel words out onto several DAC data lines, and it collects the bits on the same number of ADC lines back into a parallel frame.

Two formats are supported. Stereo mode has two 32-bit slots per frame on each line, which is 64 bit positions. TDM mode has eight 32-bit slots per frame on each line, which is 256 bit positions. Every slot runs one bit late against the word clock or frame sync. The producer is told through a one-cycle pulse each time a new output frame has been taken. A one-cycle valid strobe marks each completed input frame.

A start request is honoured only from the stopped or idle state, and only with a supported ratio. At that point the divide ratio and the format are latched. A stop request parks every clock and data output low.

Top module: `i2s_tdm_master`

## Requirements
- R1: The accepted values of `div_ratio` are 1, 2, 4, 8 and 16. A `start` with any other value, including every value above 16, is ignored: the block stays idle, no frame is taken, and the bit clock keeps its parked level.
- R2: While running, one bit period lasts `div_ratio` master-clock cycles. For a ratio of 2 or more, the bit clock is low in the first half of the period and high in the second half. For a ratio of 1, the bit clock is the inverted master clock. In both cases the bit clock is high in the last master-clock cycle of each bit.
- R3: After reset, and before the first start, the bit clock idles high while the word clock and data lines are low. One cycle after `stop`, the bit clock, word clock and all data lines are low, and they stay there until the next accepted start.
- R4: Slots are 32 bits wide and are sent MSB first, one bit late. Slot s of a frame occupies bit positions 32s+1 to 32s+32. Position 0 of a frame carries bit 0 of the last slot of the previous frame, or 0 for the first frame after a start.
- R5: In stereo mode (`tdm_mode`=0, 64 positions), the word clock is low at positions 0 to 31 and high at positions 32 to 63.
- R6: In TDM mode (`tdm_mode`=1, 256 positions), the frame sync is high only at position 0. Its rising edge marks the start of a frame.
- R7: Channel c is carried in `tx_frame`/`rx_frame` bits [32c+31:32c]. Line n carries channel n·S+s in slot s, where S is 2 in stereo mode and 8 in TDM mode.
- R8: `tx_frame` is latched when position 0 of each frame begins, and at the same moment `tx_take` pulses high for one cycle.
- R9: Each ADC line is sampled at the end of every bit, using the same one-bit-late slot layout as the output. When the last bit of a frame has been sampled (at position 0 of the next frame), `rx_frame` is updated and `rx_valid` pulses for one cycle. There is no strobe for the frame that is in progress when a start occurs.
- R10: `div_ratio` and `tdm_mode` take effect only on an accepted start. Changing them, or pulsing `start`, while the block is running has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin streaming |
| stop | input | 1 | Format or rate change: park all outputs low |
| tdm_mode | input | 1 | 0 selects stereo, 1 selects 8-slot TDM |
| div_ratio | input | 5 | Master clocks per bit clock |
| tx_frame | input | LINES*256 | Channel words to send, 32 bits per channel |
| adc_sd | input | LINES | Serial ADC data lines |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock (stereo) or frame sync (TDM) |
| dac_sd | output | LINES | Serial DAC data lines |
| tx_take | output | 1 | One-cycle pulse when `tx_frame` is latched |
| rx_frame | output | LINES*256 | Last complete captured frame |
| rx_valid | output | 1 | One-cycle pulse when `rx_frame` is updated |

## Verification
The hardest cases to reach are the frame boundary and the ignored reconfiguration. At the frame boundary, one bit of the previous frame's last slot goes out and comes in while the next frame is already latched. The reconfiguration case is a ratio, format or start change made in the middle of a run. The bench streams several back-to-back frames at each divide ratio and in both formats, and gives every frame fresh random channel words. This shows whether a wrongly chosen frame or a stale carry bit at position 0 corrupts the boundary bit on either path. In some runs the bench changes the ratio and the format and pulses start early in the first frame. Its timing model keeps the original settings, so any restart or rescaling shows up as a bit mismatch.

// File: rtl/i2s_ser_pkg.sv
`timescale 1ns/1ps
package i2s_ser_pkg;
  localparam int SLOT_W = 32;
  localparam int TDM_SLOTS = 8;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_RUN  = 2'd1,
    SER_PARK = 2'd2
  } ser_state_e;

  // only powers of two up to 16 are supported
  function automatic logic ratio_ok(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd2) || (r == 5'd4) || (r == 5'd8) || (r == 5'd16);
  endfunction

  function automatic logic [7:0] last_pos(input logic tdm);
    return tdm ? 8'd255 : 8'd63;
  endfunction

  function automatic logic [2:0] last_slot(input logic tdm);
    return tdm ? 3'd7 : 3'd1;
  endfunction

  // word clock / frame sync level for a frame position
  function automatic logic ws_at(input logic [7:0] p, input logic tdm);
    return tdm ? (p == 8'd0) : p[5];
  endfunction

  // slot whose bit is on the wire at position p (one-bit late)
  function automatic logic [2:0] src_slot(input logic [7:0] p);
    logic [7:0] q;
    q = p - 8'd1;
    return q[7:5];
  endfunction

  function automatic logic [4:0] src_bit(input logic [7:0] p);
    logic [7:0] q;
    q = p - 8'd1;
    return ~q[4:0];
  endfunction
endpackage

// File: rtl/i2s_bclk_gen.sv
`timescale 1ns/1ps
module i2s_bclk_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic       park_low,
  input  logic [4:0] ratio,
  output logic       bclk_q,
  output logic       bit_end
);
  logic [3:0] mc;
  logic [4:0] mc_inc;
  logic [4:0] half;

  assign half    = {1'b0, ratio[4:1]};
  assign mc_inc  = {1'b0, mc} + 5'd1;
  assign bit_end = run && (mc_inc == ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc     <= '0;
      bclk_q <= 1'b1;
    end else if (load) begin
      mc     <= '0;
      bclk_q <= 1'b0;
    end else if (run) begin
      if (bit_end) begin
        mc     <= '0;
        bclk_q <= 1'b0;
      end else begin
        mc     <= mc_inc[3:0];
        bclk_q <= (mc_inc >= half);
      end
    end else begin
      mc     <= '0;
      bclk_q <= !park_low;
    end
  end

  // R2: each bit ends in the high phase of the divided clock
  p_end_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && ratio != 5'd1) |-> bclk_q);

  // R2: the next bit starts low
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && ratio != 5'd1) |=> !bclk_q);
endmodule

// File: rtl/i2s_tx_lines.sv
`timescale 1ns/1ps
module i2s_tx_lines
  import i2s_ser_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          advance,
  input  logic                          first,
  input  logic                          park,
  input  logic                          tdm,
  input  logic [7:0]                    pos_cur,
  input  logic [7:0]                    pos_nxt,
  input  logic [LINES*TDM_SLOTS*SLOT_W-1:0] tx_frame,
  output logic [LINES-1:0]              dac,
  output logic                          ws,
  output logic                          take
);
  localparam int CHMAX = LINES * TDM_SLOTS;
  localparam int CW = (CHMAX > 1) ? $clog2(CHMAX) : 1;

  function automatic logic [CW-1:0] chan_idx(input int ln, input logic [2:0] s, input logic t);
    int c;
    c = ln * (t ? TDM_SLOTS : 2) + int'(s);
    return c[CW-1:0];
  endfunction

  logic [CHMAX-1:0][SLOT_W-1:0] frm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm  <= '0;
      dac  <= '0;
      ws   <= 1'b0;
      take <= 1'b0;
    end else begin
      take <= 1'b0;
      if (park) begin
        dac <= '0;
        ws  <= 1'b0;
      end else if (advance) begin
        ws <= ws_at(pos_nxt, tdm);
        if (pos_nxt == 8'd0) begin
          frm  <= tx_frame;
          take <= 1'b1;
        end
        for (int l = 0; l < LINES; l++) begin
          if (pos_nxt == 8'd0)
            dac[l] <= first ? 1'b0 : frm[chan_idx(l, last_slot(tdm), tdm)][0];
          else
            dac[l] <= frm[chan_idx(l, src_slot(pos_nxt), tdm)][src_bit(pos_nxt)];
        end
      end
    end
  end

  // R6: TDM sync rises only at frame position 0
  p_sync_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm && $rose(ws)) |-> (pos_cur == 8'd0));

  // R8: a frame is taken only at position 0
  p_take_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pos_cur == 8'd0));
endmodule

// File: rtl/i2s_rx_lines.sv
`timescale 1ns/1ps
module i2s_rx_lines
  import i2s_ser_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          first,
  input  logic                          bit_end,
  input  logic                          tdm,
  input  logic [7:0]                    pos_cur,
  input  logic [LINES-1:0]              adc,
  output logic [LINES*TDM_SLOTS*SLOT_W-1:0] rx_frame,
  output logic                          rx_valid
);
  localparam int CHMAX = LINES * TDM_SLOTS;
  localparam int CW = (CHMAX > 1) ? $clog2(CHMAX) : 1;

  function automatic logic [CW-1:0] chan_idx(input int ln, input logic [2:0] s, input logic t);
    int c;
    c = ln * (t ? TDM_SLOTS : 2) + int'(s);
    return c[CW-1:0];
  endfunction

  logic [CHMAX-1:0][SLOT_W-1:0] acc;
  logic [CHMAX-1:0][SLOT_W-1:0] hold;
  logic                         primed;

  assign rx_frame = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      hold     <= '0;
      primed   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (first) begin
        acc    <= '0;
        primed <= 1'b0;
      end else if (bit_end) begin
        if (pos_cur == 8'd0) begin
          if (primed) begin
            hold <= acc;
            for (int l = 0; l < LINES; l++)
              hold[chan_idx(l, last_slot(tdm), tdm)][0] <= adc[l];
            rx_valid <= 1'b1;
          end
        end else begin
          for (int l = 0; l < LINES; l++)
            acc[chan_idx(l, src_slot(pos_cur), tdm)][src_bit(pos_cur)] <= adc[l];
        end
        if (pos_cur == last_pos(tdm))
          primed <= 1'b1;
      end
    end
  end

  // R9: the frame strobe lasts one cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/i2s_tdm_master.sv
`timescale 1ns/1ps
module i2s_tdm_master
  import i2s_ser_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          stop,
  input  logic                          tdm_mode,
  input  logic [4:0]                    div_ratio,
  input  logic [LINES*TDM_SLOTS*SLOT_W-1:0] tx_frame,
  input  logic [LINES-1:0]              adc_sd,
  output logic                          bclk,
  output logic                          wclk,
  output logic [LINES-1:0]              dac_sd,
  output logic                          tx_take,
  output logic [LINES*TDM_SLOTS*SLOT_W-1:0] rx_frame,
  output logic                          rx_valid
);
  ser_state_e state;
  logic [4:0] ratio_q;
  logic       tdm_q;
  logic [7:0] pos;
  logic [7:0] pos_nxt;
  logic       start_ok;
  logic       running;
  logic       gen_run;
  logic       park_low;
  logic       bit_end;
  logic       advance;
  logic       tdm_eff;
  logic       bclk_q;

  assign running  = (state == SER_RUN);
  assign start_ok = start && !stop && !running && ratio_ok(div_ratio);
  assign gen_run  = running && !stop;
  assign park_low = stop || (state == SER_PARK);
  assign advance  = start_ok || bit_end;
  assign tdm_eff  = start_ok ? tdm_mode : tdm_q;
  assign pos_nxt  = (start_ok || pos == last_pos(tdm_q)) ? 8'd0 : pos + 8'd1;

  // ratio 1: the master clock itself, inverted so data moves on its falling phase
  assign bclk = (running && ratio_q == 5'd1) ? ~clk : bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SER_IDLE;
      ratio_q <= 5'd1;
      tdm_q   <= 1'b0;
      pos     <= '0;
    end else if (stop) begin
      state <= SER_PARK;
      pos   <= '0;
    end else if (start_ok) begin
      state   <= SER_RUN;
      ratio_q <= div_ratio;
      tdm_q   <= tdm_mode;
      pos     <= '0;
    end else if (bit_end) begin
      pos <= pos_nxt;
    end
  end

  i2s_bclk_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .run      (gen_run),
    .park_low (park_low),
    .ratio    (ratio_q),
    .bclk_q   (bclk_q),
    .bit_end  (bit_end)
  );

  i2s_tx_lines #(.LINES(LINES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .first    (start_ok),
    .park     (stop),
    .tdm      (tdm_eff),
    .pos_cur  (pos),
    .pos_nxt  (pos_nxt),
    .tx_frame (tx_frame),
    .dac      (dac_sd),
    .ws       (wclk),
    .take     (tx_take)
  );

  i2s_rx_lines #(.LINES(LINES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .first    (start_ok),
    .bit_end  (bit_end),
    .tdm      (tdm_q),
    .pos_cur  (pos),
    .adc      (adc_sd),
    .rx_frame (rx_frame),
    .rx_valid (rx_valid)
  );

  // R1: an unsupported ratio never starts the port
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !running && !ratio_ok(div_ratio)) |=> (state != SER_RUN));

  // R10: configuration is frozen while running
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(ratio_q) && $stable(tdm_q)));

  // R3: stop parks every output low
  p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!bclk_q && !wclk && dac_sd == '0));
endmodule

// File: tb/test_i2s_tdm_master.sv
`timescale 1ns/1ps
module test_i2s_tdm_master;
  localparam int LINES = 2;
  localparam int FW = LINES * 8 * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic tdm_mode = 1'b0;
  logic [4:0] div_ratio = 5'd1;
  logic [FW-1:0] tx_frame = '0;
  logic [LINES-1:0] adc_sd = '0;
  logic bclk, wclk, tx_take, rx_valid;
  logic [LINES-1:0] dac_sd;
  logic [FW-1:0] rx_frame;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2s_tdm_master #(.LINES(LINES)) i_i2s_tdm_master (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tdm_mode(tdm_mode),
    .div_ratio(div_ratio), .tx_frame(tx_frame), .adc_sd(adc_sd), .bclk(bclk),
    .wclk(wclk), .dac_sd(dac_sd), .tx_take(tx_take), .rx_frame(rx_frame),
    .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] rand_frame();
    logic [FW-1:0] v;
    for (int i = 0; i < FW / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // expected serial bit on line ln at position p (slot layout one bit late)
  function automatic bit model_bit(input logic [FW-1:0] cur, input logic [FW-1:0] prev,
                                   input bit first_fr, input int ln, input int p, input bit tdm);
    int s_per = tdm ? 8 : 2;
    int k;
    if (p == 0) return first_fr ? 1'b0 : prev[32 * (ln * s_per + s_per - 1)];
    k = p - 1;
    return cur[32 * (ln * s_per + k / 32) + (31 - k % 32)];
  endfunction

  function automatic bit model_ws(input int p, input bit tdm);
    if (tdm) return p == 0;
    return (p / 32) == 1;
  endfunction

  task automatic expect_idle(input int ncyc, input bit lvl, input string tag);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      chk(bclk == lvl && tx_take == 1'b0, tag, {bclk, tx_take}, {lvl, 1'b0});
    end
  endtask

  task automatic try_bad_start(input logic [4:0] r, input bit lvl);
    @(negedge clk);
    div_ratio = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_idle(20, lvl, "R1 bad ratio ignored");
  endtask

  task automatic run_case(input bit tdm, input int d, input int nfr, input bit disturb);
    int bits = tdm ? 256 : 64;
    int s_per = tdm ? 8 : 2;
    logic [FW-1:0] lat, lat_prev, pend, build, done_rx;
    logic [LINES-1:0] a;
    logic [LINES-1:0] ex;
    lat = rand_frame();
    lat_prev = '0;
    pend = '0;
    build = '0;
    done_rx = '0;
    @(negedge clk);
    tx_frame = lat;
    tdm_mode = tdm;
    div_ratio = 5'(d);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    for (int k = 0; k <= nfr * bits + 1; k++) begin
      int p = k % bits;
      int f = k / bits;
      for (int j = 0; j < d; j++) begin
        @(negedge clk);
        if (j == 0) begin
          if (p == 0) begin
            if (f > 0) begin
              lat_prev = lat;
              lat = pend;
            end
            chk(tx_take == 1'b1, "R8 take at frame start", tx_take, 1);
            pend = rand_frame();
            tx_frame = pend;
          end else if (p == 1) begin
            chk(tx_take == 1'b0, "R8 take one cycle", tx_take, 0);
          end
          if (p == 1) begin
            if (f > 0) begin
              chk(rx_valid == 1'b1, "R9 valid strobe", rx_valid, 1);
              chk(rx_frame == done_rx, "R9 R7 captured frame", rx_frame, done_rx);
            end else begin
              chk(rx_valid == 1'b0, "R9 no partial frame", rx_valid, 0);
            end
          end
          if (disturb && f == 0 && p == 3) begin
            div_ratio = (d == 16) ? 5'd2 : 5'd16;
            tdm_mode = ~tdm;
            start = 1'b1;
          end
          if (disturb && f == 0 && p == 4) start = 1'b0;
          a = LINES'($urandom);
          adc_sd = a;
          for (int l = 0; l < LINES; l++) begin
            if (p == 0) begin
              if (f > 0) build[32 * (l * s_per + s_per - 1)] = a[l];
            end else begin
              build[32 * (l * s_per + (p - 1) / 32) + (31 - (p - 1) % 32)] = a[l];
            end
          end
          if (p == 0 && f > 0) done_rx = build;
          if (d >= 2) chk(bclk == 1'b0, "R2 low phase", bclk, 0);
        end
        if (d >= 4 && j == d / 2 - 1) chk(bclk == 1'b0, "R2 half low", bclk, 0);
        if (d >= 4 && j == d / 2) chk(bclk == 1'b1, "R2 half high", bclk, 1);
        if (j == d - 1) begin
          chk(bclk == 1'b1, "R2 high at bit end", bclk, 1);
          for (int l = 0; l < LINES; l++) ex[l] = model_bit(lat, lat_prev, f == 0, l, p, tdm);
          chk(dac_sd == ex, "R4 R7 serial data", dac_sd, ex);
          if (tdm) chk(wclk == model_ws(p, tdm), "R6 frame sync", wclk, model_ws(p, tdm));
          else     chk(wclk == model_ws(p, tdm), "R5 word clock", wclk, model_ws(p, tdm));
        end
      end
    end
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(bclk == 1'b0 && wclk == 1'b0 && dac_sd == '0, "R3 parked low after stop",
        {bclk, wclk, dac_sd}, '0);
    expect_idle(5, 1'b0, "R3 stays parked");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bclk == 1'b1 && wclk == 1'b0 && dac_sd == '0 && rx_valid == 1'b0,
        "R3 reset idle levels", {bclk, wclk, dac_sd, rx_valid}, {1'b1, 1'b0, 2'b00, 1'b0});
    try_bad_start(5'd3, 1'b1);
    try_bad_start(5'd24, 1'b1);
    try_bad_start(5'd0, 1'b1);
    run_case(1'b0, 1, 3, 1'b0);
    run_case(1'b0, 2, 3, 1'b0);
    run_case(1'b0, 4, 3, 1'b1);
    try_bad_start(5'd17, 1'b0);
    run_case(1'b0, 8, 2, 1'b0);
    run_case(1'b0, 16, 2, 1'b0);
    run_case(1'b1, 1, 3, 1'b0);
    run_case(1'b1, 2, 2, 1'b1);
    run_case(1'b1, 4, 2, 1'b0);
    run_case(1'b1, 16, 2, 1'b0);
    // R10 covered by the disturbed runs above
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 180000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule